// File: doc/BRIEF.md
# Card-Side Identification and Selection Controller

This block is the device-side control logic of an embedded multimedia card. It handles power-up, identification and selection. A command-line front end decodes each host command and hands this block the command index and the 32-bit argument. The block also watches the raw level of the command wire, which serves two purposes: counting the start-up stream of ones, and detecting a host that holds the wire low to ask for boot.

From these inputs the block keeps the card state and the relative card address. For each accepted command it produces a response payload. It reports a busy indication while its internal power-up routine runs, and it raises a boot-request flag when the host asks for boot data. It also flags any command that is not legal in the current state.

State codes seen on `card_state`: idle 0, ready 1, ident 2, standby 3, transfer 4, boot-pending 5. Parameters: `INIT_CYCLES` (length of the start-up stream of ones), `PWRUP_CYCLES` (length of the internal power-up routine) and `BOOT_HOLD` (low samples that signal a boot request).

Top module: `card_ident_ctrl`

## Requirements
- R1: After a synchronous reset, `card_state` is 0 (idle), `rca` is 0x0001, and `busy`, `boot_req`, `rsp_valid` and `illegal_cmd` are all 0.
- R2: A command is rejected as illegal until `cmd_line` has been sampled high on `INIT_CYCLES` consecutive clock edges. A low sample restarts that count. The edge that completes the count does not yet accept a command; the edge after it does.
- R3: The response to an accepted index-1 command is 0x00FF8080 in bits 30:0, with bit 31 as the power-up-finished flag. Bit 7 is low-voltage support, bits 23:15 are the high-voltage window, bits 30:29 are 00 for byte access, and every other bit is 0. The host argument has no effect on this payload.
- R4: The first accepted index-1 command starts the power-up routine. `busy` is high for exactly `PWRUP_CYCLES` cycles. An index-1 command sampled before the routine has finished, including on the edge where it finishes, returns bit 31 = 0 and leaves the card idle. The next one returns bit 31 = 1 and moves the card to ready.
- R5: While the card is idle and no index-1 command has been accepted since reset or since the last return to idle, `BOOT_HOLD` consecutive low samples of `cmd_line` move the card to boot-pending, with `boot_req` = 1. A command sampled on the same edge takes priority over this entry.
- R6: An index-0 command with argument 0xFFFFFFFA moves an idle card to boot-pending if no index-1 command has been accepted. After an index-1 command has been accepted, the same command is illegal.
- R7: An index-0 command with argument 0 returns the card to idle from any state. It restores `rca` to 0x0001, clears `boot_req` and the power-up result, and gives no response. An index-0 command with any other argument, apart from the boot case of R6, is illegal.
- R8: An index-2 command in ready moves the card to ident.
- R9: In ident, an index-3 command loads `rca` from argument bits 31:16 and moves the card to standby. A zero value in those bits is illegal.
- R10: An index-7 command whose argument bits 31:16 equal `rca` moves the card from standby to transfer, or keeps it in transfer with a response. Any other address leaves a standby card in standby, and returns a transfer card to standby. Zero acts as deselect-all. In these non-matching cases there is no response.
- R11: A command index that is not legal in the current state pulses `illegal_cmd` for one cycle, leaves the state unchanged and gives no response. The legal indices are: idle {0,1}, ready {0,2}, ident {0,3}, standby and transfer {0,7}, boot-pending {0}.
- R12: An accepted command with a response sets `rsp_valid` for one cycle, on the edge that samples the command. For index 2, 3 and 7 the payload holds the pre-command state code in bits 11:9, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_line | input | 1 | Sampled level of the command wire |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_index | input | 6 | Decoded command index |
| cmd_arg | input | 32 | Decoded command argument |
| rsp_valid | output | 1 | Response payload valid (one cycle) |
| rsp_payload | output | 32 | Response payload |
| card_state | output | 3 | Current state code |
| rca | output | 16 | Relative card address |
| busy | output | 1 | Power-up routine running |
| boot_req | output | 1 | Boot requested by the host |
| illegal_cmd | output | 1 | Last command was illegal (one cycle) |

## Verification
Two pairs of events can fall on the same clock edge, and both are provoked on purpose.

The first pair is the end of the power-up routine and an index-1 command. The bench counts the busy cycles one by one and places an index-1 command exactly on the edge where the routine finishes. The response must still read busy and the card must stay idle; the following command must read ready.

The second pair is the completion of the hold-low boot count and an index-1 command. The bench keeps the line low and issues the command on the edge that would complete the count. The command must win, and no boot entry may follow while the line stays low.

// File: rtl/card_ident_pkg.sv
package card_ident_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READY = 3'd1,
        ST_IDENT = 3'd2,
        ST_STBY  = 3'd3,
        ST_XFER  = 3'd4,
        ST_BOOT  = 3'd5
    } card_state_e;

    localparam logic [5:0]  CMD_GO_IDLE = 6'd0;
    localparam logic [5:0]  CMD_SEND_OP = 6'd1;
    localparam logic [5:0]  CMD_ALL_CID = 6'd2;
    localparam logic [5:0]  CMD_SET_RCA = 6'd3;
    localparam logic [5:0]  CMD_SELECT  = 6'd7;

    localparam logic [31:0] OCR_BASE    = 32'h00FF_8080;
    localparam logic [31:0] BOOT_ARG    = 32'hFFFF_FFFA;
    localparam logic [15:0] RCA_DEFAULT = 16'h0001;

    // Outcome of one decision cycle
    typedef struct packed {
        card_state_e nstate;
        logic        respond;
        logic        illegal;
        logic        load_rca;
        logic        start_pwr;
        logic        clear_pwr;
        logic        mark_cmd1;
        logic [31:0] payload;
    } step_t;

    // State code placed in bits 11:9 of a status-type payload
    function automatic logic [31:0] status_word(input card_state_e s);
        return {20'b0, s, 9'b0};
    endfunction

endpackage

// File: rtl/cid_line_monitor.sv
module cid_line_monitor #(
    parameter int INIT_CYCLES = 74,
    parameter int BOOT_HOLD   = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_line,
    output logic init_done,
    output logic hold_hit
);
    localparam int ONE_W = $clog2(INIT_CYCLES + 1);
    localparam int LOW_W = $clog2(BOOT_HOLD + 1);
    localparam logic [ONE_W-1:0] ONE_LAST = ONE_W'(INIT_CYCLES - 1);
    localparam logic [LOW_W-1:0] LOW_MAX  = LOW_W'(BOOT_HOLD);
    localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(BOOT_HOLD - 1);

    logic [ONE_W-1:0] ones_cnt;
    logic [LOW_W-1:0] low_cnt;

    // Consecutive ones before commands are honoured
    always_ff @(posedge clk) begin
        if (rst) begin
            ones_cnt  <= '0;
            init_done <= 1'b0;
        end else if (!init_done) begin
            if (!cmd_line)
                ones_cnt <= '0;
            else if (ones_cnt == ONE_LAST)
                init_done <= 1'b1;
            else
                ones_cnt <= ones_cnt + 1'b1;
        end
    end

    // Consecutive lows, saturating
    always_ff @(posedge clk) begin
        if (rst)
            low_cnt <= '0;
        else if (cmd_line)
            low_cnt <= '0;
        else if (low_cnt != LOW_MAX)
            low_cnt <= low_cnt + 1'b1;
    end

    assign hold_hit = !cmd_line && (low_cnt >= LOW_LAST);

endmodule

// File: rtl/cid_pwrup_timer.sv
module cid_pwrup_timer #(
    parameter int PWRUP_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic clear,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(PWRUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PWRUP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else if (start && !busy && !done) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == CNT_LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/card_ident_ctrl.sv
module card_ident_ctrl
    import card_ident_pkg::*;
#(
    parameter int INIT_CYCLES  = 74,
    parameter int PWRUP_CYCLES = 1000,
    parameter int BOOT_HOLD    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_line,
    input  logic        cmd_valid,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    output logic        rsp_valid,
    output logic [31:0] rsp_payload,
    output logic [2:0]  card_state,
    output logic [15:0] rca,
    output logic        busy,
    output logic        boot_req,
    output logic        illegal_cmd
);
    card_state_e state;
    step_t       step;
    logic        init_done;
    logic        hold_hit;
    logic        pwr_busy;
    logic        pwr_done;
    logic        cmd1_seen;
    logic [15:0] arg_rca;

    assign arg_rca = cmd_arg[31:16];

    cid_line_monitor #(
        .INIT_CYCLES(INIT_CYCLES),
        .BOOT_HOLD  (BOOT_HOLD)
    ) u_line (
        .clk      (clk),
        .rst      (rst),
        .cmd_line (cmd_line),
        .init_done(init_done),
        .hold_hit (hold_hit)
    );

    cid_pwrup_timer #(
        .PWRUP_CYCLES(PWRUP_CYCLES)
    ) u_pwr (
        .clk  (clk),
        .rst  (rst),
        .start(step.start_pwr),
        .clear(step.clear_pwr),
        .busy (pwr_busy),
        .done (pwr_done)
    );

    // One decision per cycle; a command beats hold-low boot entry
    always_comb begin
        step.nstate    = state;
        step.respond   = 1'b0;
        step.illegal   = 1'b0;
        step.load_rca  = 1'b0;
        step.start_pwr = 1'b0;
        step.clear_pwr = 1'b0;
        step.mark_cmd1 = 1'b0;
        step.payload   = status_word(state);
        if (cmd_valid) begin
            if (!init_done) begin
                step.illegal = 1'b1;
            end else begin
                case (cmd_index)
                    CMD_GO_IDLE: begin
                        if (cmd_arg == 32'h0) begin
                            step.nstate    = ST_IDLE;
                            step.clear_pwr = 1'b1;
                        end else if (cmd_arg == BOOT_ARG && state == ST_IDLE && !cmd1_seen) begin
                            step.nstate = ST_BOOT;
                        end else begin
                            step.illegal = 1'b1;
                        end
                    end
                    CMD_SEND_OP: begin
                        if (state == ST_IDLE) begin
                            step.respond   = 1'b1;
                            step.mark_cmd1 = 1'b1;
                            step.payload   = OCR_BASE | {pwr_done, 31'b0};
                            step.start_pwr = !pwr_busy && !pwr_done;
                            if (pwr_done)
                                step.nstate = ST_READY;
                        end else begin
                            step.illegal = 1'b1;
                        end
                    end
                    CMD_ALL_CID: begin
                        if (state == ST_READY) begin
                            step.nstate  = ST_IDENT;
                            step.respond = 1'b1;
                        end else begin
                            step.illegal = 1'b1;
                        end
                    end
                    CMD_SET_RCA: begin
                        if (state == ST_IDENT && arg_rca != 16'h0) begin
                            step.nstate   = ST_STBY;
                            step.respond  = 1'b1;
                            step.load_rca = 1'b1;
                        end else begin
                            step.illegal = 1'b1;
                        end
                    end
                    CMD_SELECT: begin
                        if (state == ST_STBY) begin
                            if (arg_rca == rca) begin
                                step.nstate  = ST_XFER;
                                step.respond = 1'b1;
                            end
                        end else if (state == ST_XFER) begin
                            if (arg_rca == rca)
                                step.respond = 1'b1;
                            else
                                step.nstate = ST_STBY;
                        end else begin
                            step.illegal = 1'b1;
                        end
                    end
                    default: step.illegal = 1'b1;
                endcase
            end
        end else if (state == ST_IDLE && !cmd1_seen && hold_hit) begin
            step.nstate = ST_BOOT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            rca         <= RCA_DEFAULT;
            cmd1_seen   <= 1'b0;
            rsp_valid   <= 1'b0;
            rsp_payload <= '0;
            illegal_cmd <= 1'b0;
        end else begin
            state       <= step.nstate;
            rsp_valid   <= step.respond;
            illegal_cmd <= step.illegal;
            if (step.respond)
                rsp_payload <= step.payload;
            if (step.load_rca)
                rca <= arg_rca;
            if (step.clear_pwr) begin
                rca       <= RCA_DEFAULT;
                cmd1_seen <= 1'b0;
            end else if (step.mark_cmd1) begin
                cmd1_seen <= 1'b1;
            end
        end
    end

    assign card_state = state;
    assign busy       = pwr_busy;
    assign boot_req   = (state == ST_BOOT);

endmodule

// File: rtl/card_ident_checker.sv
module card_ident_checker
    import card_ident_pkg::*;
#(
    parameter int PWRUP_CYCLES = 1000
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [5:0]  cmd_index,
    input logic        rsp_valid,
    input logic [31:0] rsp_payload,
    input logic [2:0]  card_state,
    input logic [15:0] rca,
    input logic        busy,
    input logic        boot_req,
    input logic        illegal_cmd,
    input logic        init_done,
    input logic        cmd1_seen
);
    localparam int RUN_W = $clog2(PWRUP_CYCLES + 2);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(PWRUP_CYCLES);

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)
            busy_run <= '0;
        else if (busy && busy_run != RUN_LIM)
            busy_run <= busy_run + 1'b1;
        else if (!busy)
            busy_run <= '0;
    end

    assert_ocr_payload_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_index == CMD_SEND_OP && card_state == ST_IDLE && init_done)
        |=> (rsp_valid && rsp_payload[30:0] == OCR_BASE[30:0]));

    assert_busy_in_idle_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> card_state == ST_IDLE);

    assert_busy_window_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> busy_run < RUN_LIM);

    assert_boot_before_op_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(boot_req) |-> !$past(cmd1_seen));

    assert_rca_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        rca != 16'h0);

    assert_xfer_entry_R10: assert property (@(posedge clk) disable iff (rst)
        (card_state == ST_XFER && $past(card_state) != ST_XFER)
        |-> $past(card_state) == ST_STBY);

    assert_illegal_no_rsp_R11: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && illegal_cmd));

    assert_illegal_hold_R11: assert property (@(posedge clk) disable iff (rst)
        illegal_cmd |-> card_state == $past(card_state));

endmodule

bind card_ident_ctrl card_ident_checker #(
    .PWRUP_CYCLES(PWRUP_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_index  (cmd_index),
    .rsp_valid  (rsp_valid),
    .rsp_payload(rsp_payload),
    .card_state (card_state),
    .rca        (rca),
    .busy       (busy),
    .boot_req   (boot_req),
    .illegal_cmd(illegal_cmd),
    .init_done  (init_done),
    .cmd1_seen  (cmd1_seen)
);

// File: tb/sim_card_ident_ctrl.sv
module sim_card_ident_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int INIT = 6;
    localparam int PWR  = 5;
    localparam int HOLD = 4;
    localparam int WATCHDOG = 100000;
    localparam logic [31:0] OCR = 32'h00FF_8080;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_line = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        rsp_valid;
    logic [31:0] rsp_payload;
    logic [2:0]  card_state;
    logic [15:0] rca;
    logic        busy;
    logic        boot_req;
    logic        illegal_cmd;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_ident_ctrl #(
        .INIT_CYCLES (INIT),
        .PWRUP_CYCLES(PWR),
        .BOOT_HOLD   (HOLD)
    ) u0 (
        .clk(clk), .rst(rst), .cmd_line(cmd_line), .cmd_valid(cmd_valid),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid),
        .rsp_payload(rsp_payload), .card_state(card_state), .rca(rca),
        .busy(busy), .boot_req(boot_req), .illegal_cmd(illegal_cmd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic do_reset();
        rst = 1'b1;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [5:0] idx, input logic [31:0] arg);
        cmd_valid = 1'b1;
        cmd_index = idx;
        cmd_arg   = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic bit legal(input logic [2:0] st, input logic [5:0] idx);
        case (st)
            3'd0: return idx == 6'd0 || idx == 6'd1;
            3'd1: return idx == 6'd0 || idx == 6'd2;
            3'd2: return idx == 6'd0 || idx == 6'd3;
            3'd3, 3'd4: return idx == 6'd0 || idx == 6'd7;
            default: return idx == 6'd0;
        endcase
    endfunction

    // R11: every index not legal in state st
    task automatic sweep(input logic [2:0] st);
        for (int i = 0; i < 64; i++) begin
            if (!legal(st, 6'(i))) begin
                send(6'(i), 32'hA5A5_0000 ^ 32'(i));
                chk("R11 illegal flag", {31'b0, illegal_cmd}, 32'd1);
                chk("R11 no response", {31'b0, rsp_valid}, 32'd0);
                chk("R11 state kept", {29'b0, card_state}, {29'b0, st});
            end
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // ---------- R1 reset ----------
        cmd_line = 1'b1;
        do_reset();
        chk("R1 state", {29'b0, card_state}, 32'd0);
        chk("R1 rca", {16'b0, rca}, 32'h0001);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 boot_req", {31'b0, boot_req}, 32'd0);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R1 illegal", {31'b0, illegal_cmd}, 32'd0);

        // ---------- R2 start-up stream ----------
        idle(2);
        send(6'd1, 32'h0);
        chk("R2 early command illegal", {31'b0, illegal_cmd}, 32'd1);
        cmd_line = 1'b0;
        idle(1);
        cmd_line = 1'b1;
        idle(INIT - 1);
        send(6'd1, 32'h0);   // completes the count: still rejected
        chk("R2 boundary edge illegal", {31'b0, illegal_cmd}, 32'd1);
        chk("R2 boundary no response", {31'b0, rsp_valid}, 32'd0);

        sweep(3'd0);

        // ---------- R3 / R4 power-up handshake ----------
        send(6'd1, 32'hFFFF_FFFF);
        chk("R3 first payload", rsp_payload, OCR);
        chk("R12 rsp_valid on op", {31'b0, rsp_valid}, 32'd1);
        chk("R4 busy starts", {31'b0, busy}, 32'd1);
        for (int j = 1; j < PWR; j++) begin
            idle(1);
            chk("R4 busy held", {31'b0, busy}, 32'd1);
            chk("R4 still idle", {29'b0, card_state}, 32'd0);
        end
        send(6'd1, 32'h0000_0000);  // lands on the finishing edge
        chk("R4 same-edge payload busy", rsp_payload, OCR);
        chk("R4 same-edge stays idle", {29'b0, card_state}, 32'd0);
        chk("R4 busy cleared", {31'b0, busy}, 32'd0);
        send(6'd1, 32'h1234_5678);
        chk("R3 ready payload", rsp_payload, OCR | 32'h8000_0000);
        chk("R4 ready state", {29'b0, card_state}, 32'd1);

        // ---------- R8 ready -> ident ----------
        sweep(3'd1);
        send(6'd2, 32'h0);
        chk("R8 ident state", {29'b0, card_state}, 32'd2);
        chk("R12 status payload ready", rsp_payload, 32'd1 << 9);

        // ---------- R9 address assignment ----------
        sweep(3'd2);
        send(6'd3, 32'h0000_FFFF);
        chk("R9 zero rca illegal", {31'b0, illegal_cmd}, 32'd1);
        chk("R9 zero rca keeps rca", {16'b0, rca}, 32'h0001);
        send(6'd3, 32'hBEEF_0000);
        chk("R9 standby state", {29'b0, card_state}, 32'd3);
        chk("R9 rca loaded", {16'b0, rca}, 32'h0000_BEEF);
        chk("R12 status payload ident", rsp_payload, 32'd2 << 9);

        // ---------- R10 select / deselect ----------
        sweep(3'd3);
        send(6'd7, 32'h1234_0000);
        chk("R10 other address stays", {29'b0, card_state}, 32'd3);
        chk("R10 other address silent", {31'b0, rsp_valid}, 32'd0);
        chk("R10 other address legal", {31'b0, illegal_cmd}, 32'd0);
        send(6'd7, 32'h0);
        chk("R10 zero in standby stays", {29'b0, card_state}, 32'd3);
        chk("R10 zero in standby silent", {31'b0, rsp_valid}, 32'd0);
        send(6'd7, 32'hBEEF_0000);
        chk("R10 selected", {29'b0, card_state}, 32'd4);
        chk("R12 status payload standby", rsp_payload, 32'd3 << 9);
        sweep(3'd4);
        send(6'd7, 32'hBEEF_0000);
        chk("R10 reselect keeps transfer", {29'b0, card_state}, 32'd4);
        chk("R12 status payload transfer", rsp_payload, 32'd4 << 9);
        send(6'd7, 32'h0000_0001);
        chk("R10 deselect all", {29'b0, card_state}, 32'd3);
        chk("R10 deselect silent", {31'b0, rsp_valid}, 32'd0);
        send(6'd7, 32'hBEEF_0000);
        send(6'd7, 32'h4321_0000);
        chk("R10 other address deselects", {29'b0, card_state}, 32'd3);

        // ---------- R7 return to idle ----------
        send(6'd7, 32'hBEEF_0000);
        send(6'd0, 32'h0000_0005);
        chk("R7 odd argument illegal", {31'b0, illegal_cmd}, 32'd1);
        chk("R7 odd argument keeps state", {29'b0, card_state}, 32'd4);
        send(6'd0, 32'h0);
        chk("R7 idle", {29'b0, card_state}, 32'd0);
        chk("R7 rca restored", {16'b0, rca}, 32'h0001);
        chk("R7 no response", {31'b0, rsp_valid}, 32'd0);
        send(6'd1, 32'h0);
        chk("R7 power-up rerun", rsp_payload, OCR);
        chk("R7 busy again", {31'b0, busy}, 32'd1);
        send(6'd0, 32'hFFFF_FFFA);
        chk("R6 boot after op illegal", {31'b0, illegal_cmd}, 32'd1);
        chk("R6 no boot after op", {31'b0, boot_req}, 32'd0);

        // ---------- R6 boot by argument ----------
        do_reset();
        idle(INIT);
        send(6'd0, 32'hFFFF_FFFA);
        chk("R6 boot state", {29'b0, card_state}, 32'd5);
        chk("R6 boot_req", {31'b0, boot_req}, 32'd1);
        chk("R6 no response", {31'b0, rsp_valid}, 32'd0);
        sweep(3'd5);
        send(6'd0, 32'h0);
        chk("R7 boot cleared", {31'b0, boot_req}, 32'd0);
        chk("R7 boot to idle", {29'b0, card_state}, 32'd0);

        // ---------- R5 boot by holding the line low ----------
        cmd_line = 1'b0;
        do_reset();
        for (int j = 1; j <= HOLD; j++) begin
            idle(1);
            chk("R5 hold-low state", {29'b0, card_state}, (j == HOLD) ? 32'd5 : 32'd0);
            chk("R5 hold-low flag", {31'b0, boot_req}, (j == HOLD) ? 32'd1 : 32'd0);
        end
        cmd_line = 1'b1;
        idle(INIT);
        send(6'd0, 32'h0);
        chk("R5 released to idle", {29'b0, card_state}, 32'd0);

        // ---------- R5 command wins on the same edge ----------
        do_reset();
        idle(INIT);
        cmd_line = 1'b0;
        idle(HOLD - 1);
        send(6'd1, 32'h0);
        chk("R5 op wins response", {31'b0, rsp_valid}, 32'd1);
        chk("R5 op wins state", {29'b0, card_state}, 32'd0);
        idle(3);
        chk("R5 no boot after op", {31'b0, boot_req}, 32'd0);
        chk("R5 idle after op", {29'b0, card_state}, 32'd0);
        cmd_line = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule